// File: doc/BRIEF.md
# Big-Endian Sample Lane Burst Adapter

This block sits between a DMA engine and the 32-bit data register of a serial audio peripheral whose byte order is big-endian. It moves one audio segment at a time. For playback it takes samples from memory and writes them to the peripheral's transmit register. For capture it reads the receive register and hands the samples to memory. From a sample width code it works out three things: the access size, the byte offset of the narrow sample inside the big-endian register word, and the byte-lane enables. A narrow sample sits in the low-order lanes of the register, so the address must point past the unused high-order bytes.

The peripheral controls the pace. Before each burst the adapter waits until the peripheral's request line shows that it is not paused. It then moves a fixed number of samples, and after that it checks the request line again. A stereo frame is two samples. A playback burst is two frames, so the transmit FIFO, which holds three frames, always has room. A capture burst is one frame, which matches the level at which the receive FIFO signals. The last burst of a segment may be shorter. A packed 24-bit width code is rejected with an error flag, because three-byte accesses do not exist.

Each access completes in a single cycle. It completes when the adapter presents it and both the peripheral and the memory side are ready in that cycle.

Top module: `lane_adapter`

## Requirements
- R1: After reset, xferValid, busy, segDone, widthErr and perByteEn are all 0.
- R2: The width code sets perSize. Code 0 (8-bit) gives 1 byte, code 1 (16-bit) gives 2 bytes and code 2 (32-bit) gives 4 bytes. The code is latched when a segment is accepted.
- R3: perAddr equals regBase + 4 − perSize. That is +3 for 8-bit, +2 for 16-bit and +0 for 32-bit.
- R4: perByteEn bit i covers data bits [8i+7:8i]. During an access the low perSize bits are set: 0001, 0011 or 1111. Outside an access perByteEn is 0.
- R5: During a playback access, perWdata equals memRdData masked to the low perSize bytes. During a capture access, memWdata equals perRdata masked the same way. Each data output is 0 at all other times.
- R6: A segStart with width code 3 (packed 24-bit) sets widthErr one cycle later. It starts no transfer and leaves the latched width unchanged. The next accepted segStart with a supported code clears widthErr.
- R7: A playback burst is 4 accesses (two frames). A capture burst is 2 accesses (one frame). Only the last burst of a segment may be shorter.
- R8: An accepted segment first enters a check cycle. A burst starts only on the cycle after perReq is sampled high in a check cycle. After every burst that does not end the segment, the adapter returns to the check state.
- R9: An access completes only in a cycle where xferValid, perReady and memReady are all high. A segment completes exactly segSamples accesses.
- R10: busy is high from the cycle after an accepted segStart until segDone. segDone is a one-cycle pulse in the cycle after the last access, and busy is low while it is high.
- R11: A segStart that arrives while busy is ignored.
- R12: A supported segStart with segSamples = 0 pulses segDone in the next cycle and makes no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segStart | input | 1 | Start a segment (sampled while idle) |
| cfgWidth | input | 2 | Sample width code: 0=8, 1=16, 2=32, 3=packed 24 (rejected) |
| cfgCapture | input | 1 | 1 = capture, 0 = playback |
| segSamples | input | CNT_W | Samples in the segment |
| regBase | input | ADDR_W | Address of the peripheral data register word |
| perReq | input | 1 | Peripheral ready for a burst (low = pause) |
| perReady | input | 1 | Peripheral accepts/provides an access this cycle |
| memReady | input | 1 | Memory side provides/accepts data this cycle |
| memRdData | input | DATA_W | Playback sample from memory, right-aligned |
| perRdata | input | DATA_W | Capture register word from the peripheral |
| xferValid | output | 1 | Access presented this cycle |
| perAddr | output | ADDR_W | Peripheral access address including lane offset |
| perByteEn | output | DATA_W/8 | Byte-lane enables |
| perSize | output | $clog2(DATA_W/8)+1 | Access size in bytes |
| perWdata | output | DATA_W | Playback data toward the peripheral |
| memWdata | output | DATA_W | Capture data toward memory |
| busy | output | 1 | Segment in progress |
| segDone | output | 1 | One-cycle end-of-segment pulse |
| widthErr | output | 1 | Unsupported width requested |

## Verification
Addressing, size, lane enables and data are combinational from the latched width. They are due in the same cycle that xferValid is high. xferValid itself rises one cycle after perReq is seen high in a check cycle. busy and widthErr follow segStart by one cycle, and segDone follows the last completed access by one cycle. The bench keeps a behavioural model that advances on each rising edge. It compares every output 1 ns after the falling edge, once the registered outputs have settled and the new inputs are stable. Burst length is counted at the ports and checked when xferValid falls. The access total is checked when segDone pulses.

// File: rtl/lane_adapter_pkg.sv
package lane_adapter_pkg;

  // Width codes seen on cfgWidth
  localparam logic [1:0] WCODE_8   = 2'd0;
  localparam logic [1:0] WCODE_16  = 2'd1;
  localparam logic [1:0] WCODE_32  = 2'd2;
  localparam logic [1:0] WCODE_24P = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_BURST = 2'd2
  } adState_e;

  // Strobes from control to the lane datapath
  typedef struct packed {
    logic       loadCfg;
    logic [1:0] widthSel;
    logic       drive;
    logic       isCapture;
  } laneCtrl_t;

  function automatic logic widthSupported(input logic [1:0] code);
    return code != WCODE_24P;
  endfunction

endpackage

// File: rtl/lane_adapter_ctrl.sv
module lane_adapter_ctrl
  import lane_adapter_pkg::*;
#(
  parameter int CNT_W             = 16,
  parameter int TX_BURST_FRAMES   = 2,
  parameter int RX_BURST_FRAMES   = 1,
  parameter int SAMPLES_PER_FRAME = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             segStart,
  input  logic [1:0]       cfgWidth,
  input  logic             cfgCapture,
  input  logic [CNT_W-1:0] segSamples,
  input  logic             perReq,
  input  logic             perReady,
  input  logic             memReady,
  output laneCtrl_t        ctrl,
  output logic             xferValid,
  output logic             busy,
  output logic             segDone,
  output logic             widthErr
);

  localparam int TX_ACC  = TX_BURST_FRAMES * SAMPLES_PER_FRAME;
  localparam int RX_ACC  = RX_BURST_FRAMES * SAMPLES_PER_FRAME;
  localparam int MAX_ACC = (TX_ACC > RX_ACC) ? TX_ACC : RX_ACC;
  localparam int BL_W    = $clog2(MAX_ACC + 1);

  adState_e         state;
  logic [CNT_W-1:0] remain;
  logic [BL_W-1:0]  burstLeft;
  logic             capMode;

  logic             fire;
  logic             acceptStart;
  logic [BL_W-1:0]  accPerBurst;
  logic [BL_W-1:0]  firstLen;

  assign fire        = (state == ST_BURST) && perReady && memReady;
  assign acceptStart = (state == ST_IDLE) && segStart && widthSupported(cfgWidth);
  assign accPerBurst = capMode ? BL_W'(RX_ACC) : BL_W'(TX_ACC);
  assign firstLen    = (remain < CNT_W'(accPerBurst)) ? BL_W'(remain) : accPerBurst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remain    <= '0;
      burstLeft <= '0;
      capMode   <= 1'b0;
      segDone   <= 1'b0;
      widthErr  <= 1'b0;
    end else begin
      segDone <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (segStart) begin
            if (!widthSupported(cfgWidth)) begin
              widthErr <= 1'b1;
            end else begin
              widthErr <= 1'b0;
              capMode  <= cfgCapture;
              if (segSamples == '0) begin
                segDone <= 1'b1;
              end else begin
                remain <= segSamples;
                state  <= ST_CHECK;
              end
            end
          end
        end
        ST_CHECK: begin
          if (perReq) begin
            burstLeft <= firstLen;
            state     <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (fire) begin
            remain    <= remain - 1'b1;
            burstLeft <= burstLeft - 1'b1;
            if (remain == CNT_W'(1)) begin
              state   <= ST_IDLE;
              segDone <= 1'b1;
            end else if (burstLeft == BL_W'(1)) begin
              state <= ST_CHECK;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign xferValid      = (state == ST_BURST);
  assign busy           = (state != ST_IDLE);
  assign ctrl.loadCfg   = acceptStart;
  assign ctrl.widthSel  = cfgWidth;
  assign ctrl.drive     = (state == ST_BURST);
  assign ctrl.isCapture = capMode;

endmodule

// File: rtl/lane_adapter_lanes.sv
module lane_adapter_lanes
  import lane_adapter_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int REG_BYTES = DATA_W / 8,
  localparam int SZ_W      = $clog2(REG_BYTES) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  laneCtrl_t            ctrl,
  input  logic [ADDR_W-1:0]    regBase,
  input  logic [DATA_W-1:0]    memRdData,
  input  logic [DATA_W-1:0]    perRdata,
  output logic [ADDR_W-1:0]    perAddr,
  output logic [REG_BYTES-1:0] perByteEn,
  output logic [SZ_W-1:0]      perSize,
  output logic [DATA_W-1:0]    perWdata,
  output logic [DATA_W-1:0]    memWdata
);

  logic [1:0]           widthReg;
  logic [SZ_W-1:0]      sizeBytes;
  logic [REG_BYTES-1:0] laneOn;
  logic [DATA_W-1:0]    laneMask;

  always_ff @(posedge clk) begin
    if (!rstN) widthReg <= WCODE_8;
    else if (ctrl.loadCfg) widthReg <= ctrl.widthSel;
  end

  assign sizeBytes = SZ_W'(1) << widthReg;

  // Big-endian word: a narrow sample sits in the low-order lanes,
  // which are at the highest byte addresses.
  assign perAddr = regBase + ADDR_W'(REG_BYTES) - ADDR_W'(sizeBytes);
  assign perSize = sizeBytes;

  for (genvar i = 0; i < REG_BYTES; i++) begin : g_lane
    assign laneOn[i]          = (SZ_W'(i) < sizeBytes);
    assign laneMask[8*i +: 8] = {8{laneOn[i]}};
  end

  assign perByteEn = ctrl.drive ? laneOn : '0;
  assign perWdata  = (ctrl.drive && !ctrl.isCapture) ? (memRdData & laneMask) : '0;
  assign memWdata  = (ctrl.drive &&  ctrl.isCapture) ? (perRdata & laneMask) : '0;

endmodule

// File: rtl/lane_adapter.sv
module lane_adapter
  import lane_adapter_pkg::*;
#(
  parameter int ADDR_W            = 32,
  parameter int DATA_W            = 32,
  parameter int CNT_W             = 16,
  parameter int TX_BURST_FRAMES   = 2,
  parameter int RX_BURST_FRAMES   = 1,
  parameter int SAMPLES_PER_FRAME = 2,
  localparam int REG_BYTES = DATA_W / 8,
  localparam int SZ_W      = $clog2(REG_BYTES) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 segStart,
  input  logic [1:0]           cfgWidth,
  input  logic                 cfgCapture,
  input  logic [CNT_W-1:0]     segSamples,
  input  logic [ADDR_W-1:0]    regBase,
  input  logic                 perReq,
  input  logic                 perReady,
  input  logic                 memReady,
  input  logic [DATA_W-1:0]    memRdData,
  input  logic [DATA_W-1:0]    perRdata,
  output logic                 xferValid,
  output logic [ADDR_W-1:0]    perAddr,
  output logic [REG_BYTES-1:0] perByteEn,
  output logic [SZ_W-1:0]      perSize,
  output logic [DATA_W-1:0]    perWdata,
  output logic [DATA_W-1:0]    memWdata,
  output logic                 busy,
  output logic                 segDone,
  output logic                 widthErr
);

  laneCtrl_t ctrl;

  lane_adapter_ctrl #(
    .CNT_W            (CNT_W),
    .TX_BURST_FRAMES  (TX_BURST_FRAMES),
    .RX_BURST_FRAMES  (RX_BURST_FRAMES),
    .SAMPLES_PER_FRAME(SAMPLES_PER_FRAME)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .segStart  (segStart),
    .cfgWidth  (cfgWidth),
    .cfgCapture(cfgCapture),
    .segSamples(segSamples),
    .perReq    (perReq),
    .perReady  (perReady),
    .memReady  (memReady),
    .ctrl      (ctrl),
    .xferValid (xferValid),
    .busy      (busy),
    .segDone   (segDone),
    .widthErr  (widthErr)
  );

  lane_adapter_lanes #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_lanes (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .regBase  (regBase),
    .memRdData(memRdData),
    .perRdata (perRdata),
    .perAddr  (perAddr),
    .perByteEn(perByteEn),
    .perSize  (perSize),
    .perWdata (perWdata),
    .memWdata (memWdata)
  );

endmodule

// File: rtl/lane_adapter_chk.sv
module lane_adapter_chk #(
  parameter int DATA_W  = 32,
  parameter int MAX_ACC = 4,
  localparam int REG_BYTES = DATA_W / 8,
  localparam int SZ_W      = $clog2(REG_BYTES) + 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 xferValid,
  input logic                 perReq,
  input logic                 perReady,
  input logic                 memReady,
  input logic [REG_BYTES-1:0] perByteEn,
  input logic [SZ_W-1:0]      perSize,
  input logic                 busy,
  input logic                 segDone,
  input logic                 widthErr
);

  int unsigned runCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !xferValid) runCnt <= 0;
    else if (perReady && memReady) runCnt <= runCnt + 1;
  end

  // R6
  width_err_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    widthErr |-> !xferValid);

  // R4
  lane_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> ($countones(perByteEn) == int'(perSize)));

  // R7
  burst_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= MAX_ACC);

  // R8
  req_before_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferValid) |-> $past(perReq));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    segDone |-> !busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    segDone |=> !segDone);

  // R10
  valid_implies_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> busy);

endmodule

bind lane_adapter lane_adapter_chk #(
  .DATA_W (DATA_W),
  .MAX_ACC((TX_BURST_FRAMES > RX_BURST_FRAMES ? TX_BURST_FRAMES : RX_BURST_FRAMES) * SAMPLES_PER_FRAME)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .xferValid(xferValid),
  .perReq   (perReq),
  .perReady (perReady),
  .memReady (memReady),
  .perByteEn(perByteEn),
  .perSize  (perSize),
  .busy     (busy),
  .segDone  (segDone),
  .widthErr (widthErr)
);

// File: tb/lane_adapter_bench.sv
`timescale 1ns/100ps
module lane_adapter_bench;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int TX_ACC = 4;
  localparam int RX_ACC = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          segStart = 1'b0;
  logic [1:0]    cfgWidth = 2'd0;
  logic          cfgCapture = 1'b0;
  logic [CW-1:0] segSamples = '0;
  logic [AW-1:0] regBase = 32'h4000_1000;
  logic          perReq = 1'b0;
  logic          perReady = 1'b0;
  logic          memReady = 1'b0;
  logic [DW-1:0] memRdData = '0;
  logic [DW-1:0] perRdata = '0;
  logic          xferValid;
  logic [AW-1:0] perAddr;
  logic [3:0]    perByteEn;
  logic [2:0]    perSize;
  logic [DW-1:0] perWdata;
  logic [DW-1:0] memWdata;
  logic          busy;
  logic          segDone;
  logic          widthErr;

  lane_adapter u_lane_adapter (
    .clk(clk), .rstN(rstN), .segStart(segStart), .cfgWidth(cfgWidth),
    .cfgCapture(cfgCapture), .segSamples(segSamples), .regBase(regBase),
    .perReq(perReq), .perReady(perReady), .memReady(memReady),
    .memRdData(memRdData), .perRdata(perRdata), .xferValid(xferValid),
    .perAddr(perAddr), .perByteEn(perByteEn), .perSize(perSize),
    .perWdata(perWdata), .memWdata(memWdata), .busy(busy),
    .segDone(segDone), .widthErr(widthErr)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int mState, mRemain, mBurstLeft, mWidth, expLen, dutRun, segFires, acc;
  bit mCap, mDone, mErr, prevValid;
  bit quietReq = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mRemain = 0; mBurstLeft = 0; mWidth = 0;
      mCap = 0; mDone = 0; mErr = 0; expLen = 0; dutRun = 0;
    end else begin
      if (xferValid && perReady && memReady) begin
        dutRun++;
        segFires++;
      end
      mDone = 0;
      case (mState)
        0: if (segStart) begin
             if (cfgWidth == 2'd3) mErr = 1;
             else begin
               mErr = 0; mCap = cfgCapture; mWidth = cfgWidth;
               if (segSamples == 0) mDone = 1;
               else begin mRemain = segSamples; mState = 1; end
             end
           end
        1: if (perReq) begin
             acc = mCap ? RX_ACC : TX_ACC;
             mBurstLeft = (mRemain < acc) ? mRemain : acc;
             expLen = mBurstLeft;
             mState = 2;
           end
        default: if (perReady && memReady) begin
             mRemain--; mBurstLeft--;
             if (mRemain == 0) begin mState = 0; mDone = 1; end
             else if (mBurstLeft == 0) mState = 1;
           end
      endcase
    end
  end

  // Compare every cycle, 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      int sz;
      logic [63:0] mask;
      sz = 1 << mWidth;
      mask = (64'd1 << (8 * sz)) - 64'd1;
      chk("R8 xferValid", xferValid, (mState == 2));
      chk("R10 busy", busy, (mState != 0));
      chk("R10 segDone", segDone, mDone);
      chk("R6 widthErr", widthErr, mErr);
      chk("R2 perSize", perSize, sz);
      chk("R3 perAddr", perAddr, AW'(regBase + 4 - sz));
      chk("R4 perByteEn", perByteEn, (mState == 2) ? ((1 << sz) - 1) : 0);
      chk("R5 perWdata", perWdata, (mState == 2 && !mCap) ? (memRdData & mask) : 0);
      chk("R5 memWdata", memWdata, (mState == 2 && mCap) ? (perRdata & mask) : 0);
      if (prevValid && !xferValid) begin
        chk("R7 burst length", dutRun, expLen);
        dutRun = 0;
      end
      prevValid = xferValid;
    end
  end

  // Random handshake and data
  initial begin
    forever begin
      @(negedge clk);
      perReady  = ($urandom % 4) != 0;
      memReady  = ($urandom % 5) != 0;
      perReq    = quietReq ? 1'b0 : (($urandom % 3) != 0);
      memRdData = $urandom;
      perRdata  = $urandom;
    end
  end

  task automatic pulse_start(input logic [1:0] w, input logic cap, input int n);
    @(negedge clk);
    segStart = 1'b1; cfgWidth = w; cfgCapture = cap; segSamples = CW'(n);
    @(negedge clk);
    segStart = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 5000; k++) begin
      if (segDone) break;
      @(negedge clk);
      #2;
    end
  endtask

  task automatic run_seg(input logic [1:0] w, input logic cap, input int n);
    segFires = 0;
    pulse_start(w, cap, n);
    #2;
    wait_done();
    chk("R9 accesses per segment", segFires, n);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<100000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1.5;
    // R1 reset state
    chk("R1 xferValid", xferValid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 segDone", segDone, 0);
    chk("R1 widthErr", widthErr, 0);
    chk("R1 perByteEn", perByteEn, 0);

    for (int w = 0; w < 3; w++) begin
      run_seg(2'(w), 1'b0, 11);   // playback, partial last burst
      run_seg(2'(w), 1'b1, 7);    // capture, partial last burst
      run_seg(2'(w), 1'b0, 8);    // playback, whole bursts
    end

    // R8: long pause holds the block in its check state
    quietReq = 1'b1;
    segFires = 0;
    pulse_start(2'd1, 1'b0, 5);
    repeat (20) @(negedge clk);
    #2;
    chk("R8 no access while paused", segFires, 0);
    quietReq = 1'b0;
    wait_done();
    chk("R9 accesses after pause", segFires, 5);

    // R6: packed 24-bit rejected, width kept
    pulse_start(2'd3, 1'b0, 6);
    repeat (4) @(negedge clk);
    #2;
    chk("R6 error flag set", widthErr, 1);
    chk("R6 no transfer", busy, 0);
    chk("R6 width unchanged", perSize, 2);
    run_seg(2'd2, 1'b1, 3);
    chk("R6 error cleared", widthErr, 0);

    // R11: start while busy ignored
    segFires = 0;
    pulse_start(2'd0, 1'b0, 9);
    pulse_start(2'd2, 1'b1, 3);
    #2;
    wait_done();
    chk("R11 busy start ignored", segFires, 9);

    // R12: zero-length segment
    segFires = 0;
    pulse_start(2'd1, 1'b1, 0);
    #1.5;
    chk("R12 immediate done", segDone, 1);
    chk("R12 no access", segFires, 0);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule